// File: doc/BRIEF.md
# Daisy-Chain Serializer Readout Engine

This block is an SPI master that reads a chain of identical eight-input serializer chips in one frame. A single-cycle `start` request opens the frame. Chip select stays low for the whole frame. The engine clocks in one byte per chip in the short word mode, or two bytes per chip in the long word mode. When chip select rises, it moves every chip's input byte, and in the long mode every chip's status byte, to the outputs in the same clock edge. `done` pulses in that same cycle.

The block also drives two kinds of configuration lines. The first is the shared word-mode level, which is wired to every chip in the chain. The second is the debounce-select pairs: either one pair for the whole chain, or one pair for each chip. A debounce request carries a time value and an input index. The time value is mapped to a two-bit code. Values outside the supported range are refused.

Top module: `schain_reader`

## Requirements
- R1: While reset is asserted and directly after it: `cs_n` is 1, `sclk` is 0, `busy` and `done` are 0, `in_bytes` and `stat_bytes` are all zero, every `db0`/`db1` bit is 0, and `modesel` is 0.
- R2: A `start` pulse while idle makes `cs_n` go low and `busy` go high on the next clock edge. Each frame has exactly NUM_CHIPS×W×8 rising `sclk` edges, where W is 2 when `modesel` is 0 and 1 when `modesel` is 1.
- R3: `modesel` follows `mode_8bit` while idle and holds its value for the whole frame. A 1 selects the one-byte word and a 0 selects the two-byte word.
- R4: Two-byte word mode. Received bytes are numbered k = 0, 1, 2, ... in arrival order, each taken MSB first. Byte 2i goes to `in_bytes[8i+7:8i]` and byte 2i+1 goes to `stat_bytes[8i+7:8i]`.
- R5: One-byte word mode. Received byte i goes to `in_bytes[8i+7:8i]` and `stat_bytes` is cleared to zero.
- R6: SPI mode 0. `sclk` is low whenever `cs_n` is high. The first rising edge of `sclk` comes HALF_DIV cycles after `cs_n` falls. `cs_n` rises HALF_DIV cycles after the last falling edge of `sclk`. `miso` is sampled on the rising edges.
- R7: All byte outputs change together, in the cycle in which `done` is high. `done` is high for exactly one cycle, and the outputs do not change at any other time.
- R8: A `start` that arrives while `busy` is high is ignored and produces no extra frame or extra `done`. `busy` stays high until the `done` cycle.
- R9: An accepted debounce request updates the selected pair on the next clock edge. Time 0 gives db0=0, db1=0. Times 1..25 give db0=0, db1=1. Times 26..750 give db0=1, db1=0. Times 751..3000 give db0=1, db1=1.
- R10: A request with a time above 3000, or with an input index at or beyond NUM_CHIPS×8, raises `db_reject` for one cycle and leaves every `db0`/`db1` bit unchanged.
- R11: With SHARED_DB=1 every request goes to pair 0. With SHARED_DB=0 the request goes to pair `db_pin/8`, and all other pairs keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame request pulse |
| mode_8bit | input | 1 | Requested word mode (1 = one byte per chip) |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse when the new snapshot is visible |
| sclk | output | 1 | SPI clock |
| cs_n | output | 1 | SPI chip select, active low |
| miso | input | 1 | Serial data from the chain |
| modesel | output | 1 | Word-mode level for every chip |
| in_bytes | output | NUM_CHIPS*8 | Input byte per chip, chip i at [8i+7:8i] |
| stat_bytes | output | NUM_CHIPS*8 | Status byte per chip, chip i at [8i+7:8i] |
| db_req | input | 1 | Debounce request strobe |
| db_time | input | TIME_W | Requested debounce time |
| db_pin | input | $clog2(NUM_CHIPS*8)+1 | Input index that selects the chip |
| db0 | output | SHARED_DB ? 1 : NUM_CHIPS | Debounce-select bit 0, per pair |
| db1 | output | SHARED_DB ? 1 : NUM_CHIPS | Debounce-select bit 1, per pair |
| db_reject | output | 1 | One-cycle pulse for a refused debounce request |

## Verification
The serial engine and the debounce mapper run independently, so a debounce request can land in the very clock edge that opens a frame. The bench drives `db_req` and `start` from the same cycle. It then checks two things: the pins and `db_reject` against a table model, and the frame contents through the scoreboard. A second collision is a `start` pulse raised in the middle of a frame. The bench judges it by showing that `busy` stays high, that every `done` matches an entry in the queue, and that the total count of `done` pulses equals the number of frames issued.

// File: rtl/schain_pkg.sv
package schain_pkg;

   typedef enum logic [1:0] {
      ENG_IDLE,
      ENG_LEAD,
      ENG_SHIFT,
      ENG_TRAIL
   } eng_state_t;

   localparam int unsigned DB_T_SHORT = 25;
   localparam int unsigned DB_T_MID   = 750;
   localparam int unsigned DB_LIMIT   = 3000;

   typedef struct packed {
      logic ok;
      logic db0;
      logic db1;
   } db_code_t;

   function automatic db_code_t db_lookup(input logic [31:0] t);
      db_code_t c;
      c.ok = 1'b1;
      if (t == 32'd0) begin
         c.db0 = 1'b0; c.db1 = 1'b0;
      end else if (t <= DB_T_SHORT) begin
         c.db0 = 1'b0; c.db1 = 1'b1;
      end else if (t <= DB_T_MID) begin
         c.db0 = 1'b1; c.db1 = 1'b0;
      end else if (t <= DB_LIMIT) begin
         c.db0 = 1'b1; c.db1 = 1'b1;
      end else begin
         c = '0;
      end
      return c;
   endfunction

endpackage

// File: rtl/schain_spi_engine.sv
module schain_spi_engine
   import schain_pkg::*;
#(
   parameter  int unsigned HALF_DIV = 2,
   parameter  int unsigned MAX_BITS = 48,
   localparam int unsigned CNT_W    = $clog2(HALF_DIV) + 1,
   localparam int unsigned BIT_W    = $clog2(MAX_BITS) + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [BIT_W-1:0]    last_bit,
   input  logic                miso,
   output logic                busy,
   output logic                done,
   output logic                finish,
   output logic                sclk,
   output logic                cs_n,
   output logic [MAX_BITS-1:0] shreg
);

   eng_state_t       state;
   logic [CNT_W-1:0] cnt;
   logic [BIT_W-1:0] bits_left;
   logic             tick;

   assign tick   = (cnt == CNT_W'(HALF_DIV - 1));
   assign finish = (state == ENG_TRAIL) && tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ENG_IDLE;
         cnt       <= '0;
         bits_left <= '0;
         busy      <= 1'b0;
         done      <= 1'b0;
         sclk      <= 1'b0;
         cs_n      <= 1'b1;
         shreg     <= '0;
      end else begin
         done <= 1'b0;
         if (state == ENG_IDLE) begin
            cnt <= '0;
            if (start) begin
               state     <= ENG_LEAD;
               cs_n      <= 1'b0;
               busy      <= 1'b1;
               bits_left <= last_bit;
            end
         end else begin
            cnt <= tick ? '0 : cnt + 1'b1;
            if (tick) begin
               unique case (state)
                  ENG_LEAD: begin
                     sclk  <= 1'b1;
                     shreg <= {shreg[MAX_BITS-2:0], miso};
                     state <= ENG_SHIFT;
                  end
                  ENG_SHIFT: begin
                     if (sclk) begin
                        sclk <= 1'b0;
                        if (bits_left == '0) state <= ENG_TRAIL;
                        else bits_left <= bits_left - 1'b1;
                     end else begin
                        sclk  <= 1'b1;
                        shreg <= {shreg[MAX_BITS-2:0], miso};
                     end
                  end
                  ENG_TRAIL: begin
                     cs_n  <= 1'b1;
                     busy  <= 1'b0;
                     done  <= 1'b1;
                     state <= ENG_IDLE;
                  end
                  default: state <= ENG_IDLE;
               endcase
            end
         end
      end
   end

   assert_cs_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> cs_n);
   assert_sclk_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);
   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_busy_until_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

endmodule

// File: rtl/schain_snapshot.sv
module schain_snapshot #(
   parameter  int unsigned NUM_CHIPS = 3,
   localparam int unsigned NB        = NUM_CHIPS * 8,
   localparam int unsigned MAX_BITS  = NUM_CHIPS * 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                commit,
   input  logic                mode8,
   input  logic [MAX_BITS-1:0] shreg,
   output logic [NB-1:0]       in_bytes,
   output logic [NB-1:0]       stat_bytes
);

   for (genvar i = 0; i < NUM_CHIPS; i++) begin : g_chip
      localparam int unsigned P_SHORT = (NUM_CHIPS - 1 - i) * 8;
      localparam int unsigned P_IN    = (2 * NUM_CHIPS - 1 - 2 * i) * 8;
      localparam int unsigned P_STAT  = (2 * NUM_CHIPS - 2 - 2 * i) * 8;
      logic [7:0] in_q, st_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            in_q <= '0;
            st_q <= '0;
         end else if (commit) begin
            if (mode8) begin
               in_q <= shreg[P_SHORT +: 8];
               st_q <= '0;
            end else begin
               in_q <= shreg[P_IN +: 8];
               st_q <= shreg[P_STAT +: 8];
            end
         end
      end

      assign in_bytes[i*8 +: 8]   = in_q;
      assign stat_bytes[i*8 +: 8] = st_q;
   end

   assert_snap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> ($stable(in_bytes) && $stable(stat_bytes)));

endmodule

// File: rtl/schain_db_map.sv
module schain_db_map
   import schain_pkg::*;
#(
   parameter  int unsigned NUM_CHIPS = 3,
   parameter  bit          SHARED_DB = 1'b0,
   parameter  int unsigned TIME_W    = 16,
   localparam int unsigned PIN_W     = $clog2(NUM_CHIPS * 8) + 1,
   localparam int unsigned NDB       = SHARED_DB ? 1 : NUM_CHIPS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [TIME_W-1:0] req_time,
   input  logic [PIN_W-1:0]  req_pin,
   output logic [NDB-1:0]    db0_o,
   output logic [NDB-1:0]    db1_o,
   output logic              reject
);

   db_code_t         code;
   logic [PIN_W-1:0] chip_sel;
   logic             in_range;
   logic             accept;

   assign code     = db_lookup(32'(req_time));
   assign chip_sel = req_pin >> 3;
   assign in_range = (chip_sel < PIN_W'(NUM_CHIPS));
   assign accept   = req && code.ok && in_range;

   for (genvar k = 0; k < NDB; k++) begin : g_pair
      logic hit;
      if (SHARED_DB) begin : g_shared
         assign hit = 1'b1;
      end else begin : g_each
         assign hit = (chip_sel == PIN_W'(k));
      end

      logic q0, q1;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q0 <= 1'b0;
            q1 <= 1'b0;
         end else if (accept && hit) begin
            q0 <= code.db0;
            q1 <= code.db1;
         end
      end
      assign db0_o[k] = q0;
      assign db1_o[k] = q1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reject <= 1'b0;
      else        reject <= req && !accept;
   end

   assert_db_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req && (32'(req_time) > DB_LIMIT)) |=> ($stable(db0_o) && $stable(db1_o) && reject));

endmodule

// File: rtl/schain_reader.sv
module schain_reader #(
   parameter  int unsigned NUM_CHIPS = 3,
   parameter  int unsigned HALF_DIV  = 2,
   parameter  bit          SHARED_DB = 1'b0,
   parameter  int unsigned TIME_W    = 16,
   localparam int unsigned NB        = NUM_CHIPS * 8,
   localparam int unsigned MAX_BITS  = NUM_CHIPS * 16,
   localparam int unsigned BIT_W     = $clog2(MAX_BITS) + 1,
   localparam int unsigned PIN_W     = $clog2(NB) + 1,
   localparam int unsigned NDB       = SHARED_DB ? 1 : NUM_CHIPS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              mode_8bit,
   output logic              busy,
   output logic              done,
   output logic              sclk,
   output logic              cs_n,
   input  logic              miso,
   output logic              modesel,
   output logic [NB-1:0]     in_bytes,
   output logic [NB-1:0]     stat_bytes,
   input  logic              db_req,
   input  logic [TIME_W-1:0] db_time,
   input  logic [PIN_W-1:0]  db_pin,
   output logic [NDB-1:0]    db0,
   output logic [NDB-1:0]    db1,
   output logic              db_reject
);

   if (NUM_CHIPS < 1 || HALF_DIV < 1 || TIME_W < 12 || TIME_W > 31) begin : g_bad_param
      $error("schain_reader: parameter out of range");
   end

   logic [BIT_W-1:0]    last_bit;
   logic [MAX_BITS-1:0] shreg;
   logic                finish;

   assign last_bit = mode_8bit ? BIT_W'(NB - 1) : BIT_W'(MAX_BITS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     modesel <= 1'b0;
      else if (!busy) modesel <= mode_8bit;
   end

   schain_spi_engine #(.HALF_DIV(HALF_DIV), .MAX_BITS(MAX_BITS)) u_eng (
      .clk(clk), .rst_n(rst_n), .start(start), .last_bit(last_bit), .miso(miso),
      .busy(busy), .done(done), .finish(finish), .sclk(sclk), .cs_n(cs_n),
      .shreg(shreg)
   );

   schain_snapshot #(.NUM_CHIPS(NUM_CHIPS)) u_snap (
      .clk(clk), .rst_n(rst_n), .commit(finish), .mode8(modesel), .shreg(shreg),
      .in_bytes(in_bytes), .stat_bytes(stat_bytes)
   );

   schain_db_map #(.NUM_CHIPS(NUM_CHIPS), .SHARED_DB(SHARED_DB), .TIME_W(TIME_W)) u_db (
      .clk(clk), .rst_n(rst_n), .req(db_req), .req_time(db_time), .req_pin(db_pin),
      .db0_o(db0), .db1_o(db1), .reject(db_reject)
   );

   assert_modesel_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(modesel));
   assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && cs_n && !sclk));

endmodule

// File: tb/sim_schain_reader.sv
`timescale 1ns/1ps
module sim_schain_reader;
   localparam int N     = 3;
   localparam int HALF  = 2;
   localparam int NB    = N * 8;
   localparam int PIN_W = $clog2(NB) + 1;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode_8bit = 1'b0, db_req = 1'b0;
   logic [15:0] db_time = '0;
   logic [PIN_W-1:0] db_pin = '0;
   logic busy, done, sclk, cs_n, miso, modesel, db_reject;
   logic [NB-1:0] in_bytes, stat_bytes;
   logic [N-1:0] db0, db1;

   always #2 clk = ~clk;

   schain_reader #(.NUM_CHIPS(N), .HALF_DIV(HALF), .SHARED_DB(1'b0), .TIME_W(16)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .mode_8bit(mode_8bit), .busy(busy),
      .done(done), .sclk(sclk), .cs_n(cs_n), .miso(miso), .modesel(modesel),
      .in_bytes(in_bytes), .stat_bytes(stat_bytes), .db_req(db_req), .db_time(db_time),
      .db_pin(db_pin), .db0(db0), .db1(db1), .db_reject(db_reject)
   );

   int n_cmp = 0, n_bad = 0;
   bit finished = 1'b0;

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // chain model: shifts out on falling sclk, first bit ready at cs_n fall
   logic [N*16-1:0] tx_bits = '0;
   int tx_ptr = -1;
   assign miso = (tx_ptr >= 0) ? tx_bits[tx_ptr] : 1'b0;
   always @(negedge sclk) if (!cs_n) tx_ptr = tx_ptr - 1;

   // scoreboard
   typedef struct packed { logic m8; logic [NB-1:0] iv; logic [NB-1:0] sv; } exp_t;
   exp_t sb[$];
   int done_cnt = 0;
   always @(negedge clk) begin
      if (rst_n === 1'b1 && done === 1'b1) begin
         done_cnt++;
         if (sb.size() == 0) check(1'b0, "R8 unexpected done", 64'(done_cnt), 64'(done_cnt - 1));
         else begin
            exp_t e;
            e = sb.pop_front();
            if (e.m8) begin
               check(in_bytes == e.iv, "R5 input bytes", 64'(in_bytes), 64'(e.iv));
               check(stat_bytes == '0, "R5 status cleared", 64'(stat_bytes), 64'(0));
            end else begin
               check(in_bytes == e.iv, "R4 input bytes", 64'(in_bytes), 64'(e.iv));
               check(stat_bytes == e.sv, "R4 status bytes", 64'(stat_bytes), 64'(e.sv));
            end
         end
      end
   end

   // frame timing monitor
   logic p_cs = 1'b1, p_sclk = 1'b0;
   int cyc = 0, lead_cyc = -1, trail_cyc = -1, rise_cnt = 0, last_fall = 0;
   always @(negedge clk) begin
      if (p_cs === 1'b1 && cs_n === 1'b0) begin
         cyc = 0; rise_cnt = 0; lead_cyc = -1;
      end else cyc++;
      if (p_sclk === 1'b0 && sclk === 1'b1) begin
         if (rise_cnt == 0) lead_cyc = cyc;
         rise_cnt++;
      end
      if (p_sclk === 1'b1 && sclk === 1'b0) last_fall = cyc;
      if (p_cs === 1'b0 && cs_n === 1'b1) trail_cyc = cyc - last_fall;
      p_cs = cs_n; p_sclk = sclk;
   end

   // debounce model
   logic [N-1:0] m_db0 = '0, m_db1 = '0;
   function automatic bit db_model(input int pin, input int tm);
      int c;
      c = pin / 8;
      if (tm > 3000 || c >= N) return 1'b1;
      m_db0[c] = (tm > 25);
      m_db1[c] = (tm != 0) && (tm <= 25 || tm > 750);
      return 1'b0;
   endfunction

   task automatic db_apply(input int pin, input int tm, input string req);
      bit r;
      r = db_model(pin, tm);
      db_req = 1'b1; db_time = 16'(tm); db_pin = PIN_W'(pin);
      @(negedge clk);
      db_req = 1'b0;
      check(db_reject == r, {req, " reject flag"}, 64'(db_reject), 64'(r));
      check(db0 == m_db0 && db1 == m_db1, {req, " pins"}, 64'({db0, db1}), 64'({m_db0, m_db1}));
   endtask

   task automatic run_frame(input logic m8, input logic [NB-1:0] iv, input logic [NB-1:0] sv,
                            input bit poke, input bit with_db, input int pin, input int tm);
      int L;
      exp_t e;
      logic [N*16-1:0] fb;
      bit r;
      L = m8 ? N : 2 * N;
      fb = '0;
      for (int k = 0; k < N; k++) begin
         if (m8) fb[(L-1-k)*8 +: 8] = iv[k*8 +: 8];
         else begin
            fb[(L-1-2*k)*8 +: 8] = iv[k*8 +: 8];
            fb[(L-2-2*k)*8 +: 8] = sv[k*8 +: 8];
         end
      end
      tx_bits = fb; tx_ptr = L * 8 - 1;
      mode_8bit = m8;
      @(negedge clk);
      e.m8 = m8; e.iv = iv; e.sv = m8 ? '0 : sv;
      sb.push_back(e);
      start = 1'b1;
      if (with_db) begin db_req = 1'b1; db_time = 16'(tm); db_pin = PIN_W'(pin); end
      @(negedge clk);
      start = 1'b0; db_req = 1'b0;
      check(busy == 1'b1 && cs_n == 1'b0, "R2 frame opens", 64'({busy, cs_n}), 64'(2'b10));
      check(modesel == m8, "R3 mode level", 64'(modesel), 64'(m8));
      if (with_db) begin
         r = db_model(pin, tm);
         check(db_reject == r, "R9 debounce during frame start", 64'(db_reject), 64'(r));
         check(db0 == m_db0 && db1 == m_db1, "R11 pins during frame start",
               64'({db0, db1}), 64'({m_db0, m_db1}));
      end
      mode_8bit = ~m8;
      repeat (20) @(negedge clk);
      check(modesel == m8, "R3 mode held in frame", 64'(modesel), 64'(m8));
      if (poke) begin
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         check(busy == 1'b1, "R8 busy after ignored start", 64'(busy), 64'(1));
      end
      while (done !== 1'b1) @(negedge clk);
      @(negedge clk);
      check(done == 1'b0 && busy == 1'b0, "R7 done single cycle", 64'({done, busy}), 64'(0));
      check(rise_cnt == L * 8, "R2 sclk rising edges", 64'(rise_cnt), 64'(L * 8));
      check(lead_cyc == HALF, "R6 cs lead", 64'(lead_cyc), 64'(HALF));
      check(trail_cyc == HALF, "R6 cs trail", 64'(trail_cyc), 64'(HALF));
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   int wd = 0;
   always @(negedge clk) begin
      wd++;
      if (wd > 100000 && !finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual %0d expected below 100000 cycles", wd);
         summary();
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      check(cs_n == 1'b1 && sclk == 1'b0 && busy == 1'b0 && done == 1'b0, "R1 control idle",
            64'({cs_n, sclk, busy, done}), 64'(4'b1000));
      check(in_bytes == '0 && stat_bytes == '0, "R1 bytes cleared",
            64'({in_bytes, stat_bytes}), 64'(0));
      check(db0 == '0 && db1 == '0 && modesel == 1'b0, "R1 config pins",
            64'({db0, db1, modesel}), 64'(0));
      rst_n = 1'b1;
      @(negedge clk);

      run_frame(1'b0, 24'hA5_3C_81, 24'h0F_F0_7E, 1'b0, 1'b0, 0, 0);
      run_frame(1'b0, 24'h12_34_56, 24'hFF_00_C3, 1'b1, 1'b0, 0, 0);
      run_frame(1'b1, 24'hE7_18_99, 24'hAA_AA_AA, 1'b0, 1'b0, 0, 0);
      run_frame(1'b0, 24'h01_80_FE, 24'h5A_A5_33, 1'b0, 1'b1, 17, 751);
      repeat (60) @(negedge clk);
      check(done_cnt == 4, "R8 done count", 64'(done_cnt), 64'(4));
      check(cs_n == 1'b1 && sclk == 1'b0, "R6 idle after frames", 64'({cs_n, sclk}), 64'(2'b10));

      db_apply(0, 0, "R9 time 0");
      db_apply(3, 1, "R9 time 1");
      db_apply(7, 25, "R9 time 25");
      db_apply(9, 26, "R11 chip 1 time 26");
      db_apply(15, 750, "R9 time 750");
      db_apply(16, 3000, "R11 chip 2 time 3000");
      db_apply(5, 3001, "R10 time 3001");
      db_apply(24, 10, "R10 index out of chain");
      db_apply(20, 60000, "R10 large time");

      summary();
   end
endmodule